// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front End

This block is the software-facing register file of a command-driven SPI controller. A host issues single 32-bit word reads and writes over a simple request/acknowledge interface. The block answers with identification and status words, holds the interrupt enable and pending state, and turns writes and reads at fixed offsets into pushes and pops on the controller's command, transmit and receive FIFOs. The FIFOs and the serial engine sit outside the block. They connect through valid/ready ports and report their fill levels as plain inputs.

Four conditions feed a pending register: the command FIFO running low, the transmit FIFO running low, the receive FIFO filling up, and a sync marker executed by the engine. Software clears a pending bit by writing a one to it. Each pending bit is masked by its enable bit, and any bit that survives the mask raises one level interrupt line. A soft-reset register keeps the engine held off until software releases it.

Top module: `spi_regs_top`

## Requirements
- R1: After reset, reqAck and irq are 0, engineHold is 1, and the enable and pending registers read as 0.
- R2: A read at 0x00 returns the identification word: major number in bits [23:16] (value 1), minor number in [15:8], patch number in [7:0] (defaults 0 and 0x61), and zero in the top byte.
- R3: Bit 0 of the word at 0x40 drives engineHold (1 holds the engine, 0 releases it) and reads back. engineHold never changes except in the cycle after a write to 0x40.
- R4: The 4-bit enable register at 0x80 is read/write. Bit 0 is command low, bit 1 is transmit low, bit 2 is receive high and bit 3 is sync. Higher written bits read back as 0.
- R5: The pending register at 0x84 is sticky. Writing a one to a bit clears it. A condition that holds during the clearing write wins, so the bit stays set.
- R6: A read at 0x88 returns pending AND enable. irq is 1 exactly when that masked value is non-zero.
- R7: A syncValid pulse latches syncId into the register at 0xC0 and sets pending bit 3. A later pulse overwrites the stored ID.
- R8: 0xD0 reads command FIFO depth minus cmdLevel, 0xD4 reads transmit FIFO depth minus txLevel, and 0xD8 reads rxLevel. The default depths are 16.
- R9: A write at 0xE0 presents reqWdata[15:0] on the command push port, and a write at 0xE4 presents reqWdata[7:0] on the transmit push port. The request waits until the FIFO is ready, and reqAck follows one cycle after the handshake.
- R10: A read at 0xE8 returns the receive head and pops it. When the FIFO is empty it returns 0 and does not pop. A read at 0xEC returns the head and never pops.
- R11: Every accepted request gets exactly one single-cycle reqAck, one cycle after acceptance, with read data valid in that cycle. A read of an unmapped offset returns 0, and a write to one changes nothing.
- R12: Pending bit 0 is set in every cycle with cmdLevel <= 2, bit 1 with txLevel <= 2, and bit 2 with rxLevel >= 12 (default marks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request, held until reqAck |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 8 | Byte offset of the register |
| reqWdata | input | 32 | Write data |
| reqAck | output | 1 | One-cycle acknowledge |
| rspRdata | output | 32 | Read data, valid with reqAck |
| engineHold | output | 1 | Soft reset to the engine |
| irq | output | 1 | Level interrupt |
| cmdPushValid | output | 1 | Command push request |
| cmdPushReady | input | 1 | Command FIFO can accept |
| cmdPushData | output | 16 | Command word |
| cmdLevel | input | 5 | Command FIFO fill level |
| txPushValid | output | 1 | Transmit push request |
| txPushReady | input | 1 | Transmit FIFO can accept |
| txPushData | output | 8 | Transmit byte |
| txLevel | input | 5 | Transmit FIFO fill level |
| rxPopValid | input | 1 | Receive FIFO holds a byte |
| rxPopReady | output | 1 | Pop strobe to the receive FIFO |
| rxPopData | input | 8 | Receive FIFO head byte |
| rxLevel | input | 5 | Receive FIFO fill level |
| syncValid | input | 1 | Engine executed a sync marker |
| syncId | input | 8 | ID carried by that marker |

## Verification
A request is taken at the first rising edge where it is valid and, for a push, the FIFO is ready. The acknowledge and read data then arrive one cycle later, and the bench's scoreboard matches each acknowledge, in order, against the value queued when the request was issued. Level and sync inputs change at a falling edge and are taken into pending at the next rising edge. The bench therefore changes them at least one full cycle before the read that checks them, and samples engineHold and irq only after the acknowledging cycle. FIFO handshakes are sampled a quarter period after the falling edge, once the inputs have settled and before the edge that completes them.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam logic [7:0] OFF_VERSION  = 8'h00;
  localparam logic [7:0] OFF_HOLD     = 8'h40;
  localparam logic [7:0] OFF_ENABLE   = 8'h80;
  localparam logic [7:0] OFF_PENDING  = 8'h84;
  localparam logic [7:0] OFF_SOURCE   = 8'h88;
  localparam logic [7:0] OFF_SYNC     = 8'hC0;
  localparam logic [7:0] OFF_CMD_ROOM = 8'hD0;
  localparam logic [7:0] OFF_TX_ROOM  = 8'hD4;
  localparam logic [7:0] OFF_RX_LEVEL = 8'hD8;
  localparam logic [7:0] OFF_CMD_PUSH = 8'hE0;
  localparam logic [7:0] OFF_TX_PUSH  = 8'hE4;
  localparam logic [7:0] OFF_RX_POP   = 8'hE8;
  localparam logic [7:0] OFF_RX_PEEK  = 8'hEC;

  localparam int IRQ_W        = 4;
  localparam int IRQ_CMD_LOW  = 0;
  localparam int IRQ_TX_LOW   = 1;
  localparam int IRQ_RX_HIGH  = 2;
  localparam int IRQ_SYNC     = 3;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_HOLD,
    SEL_ENABLE,
    SEL_PENDING,
    SEL_SOURCE,
    SEL_SYNC,
    SEL_CMD_ROOM,
    SEL_TX_ROOM,
    SEL_RX_LEVEL,
    SEL_RX_HEAD
  } rdSel_e;

  typedef struct packed {
    logic   accept;
    logic   wrEnable;
    logic   wrPending;
    logic   wrHold;
    logic   popRx;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_regs_ctrl.sv
module spi_regs_ctrl
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cmdPushReady,
  input  logic              txPushReady,
  input  logic              rxPopValid,
  output logic              reqAck,
  output logic              cmdPushValid,
  output logic              txPushValid,
  output logic              rxPopReady,
  output ctrlStrobes_t      strb
);

  logic ackQ;
  logic live;
  logic isWr;
  logic isRd;
  logic hitCmd;
  logic hitTx;
  logic accept;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // A request is live until it has been acknowledged once
  assign live   = reqValid && !ackQ;
  assign isWr   = live && reqWrite;
  assign isRd   = live && !reqWrite;
  assign hitCmd = isWr && at(reqAddr, OFF_CMD_PUSH);
  assign hitTx  = isWr && at(reqAddr, OFF_TX_PUSH);

  // Push writes stall until the FIFO side is ready
  assign accept = live && !(hitCmd && !cmdPushReady) && !(hitTx && !txPushReady);

  rdSel_e rdSel;
  always_comb begin
    rdSel = SEL_NONE;
    if (accept && !reqWrite) begin
      if      (at(reqAddr, OFF_VERSION))  rdSel = SEL_VERSION;
      else if (at(reqAddr, OFF_HOLD))     rdSel = SEL_HOLD;
      else if (at(reqAddr, OFF_ENABLE))   rdSel = SEL_ENABLE;
      else if (at(reqAddr, OFF_PENDING))  rdSel = SEL_PENDING;
      else if (at(reqAddr, OFF_SOURCE))   rdSel = SEL_SOURCE;
      else if (at(reqAddr, OFF_SYNC))     rdSel = SEL_SYNC;
      else if (at(reqAddr, OFF_CMD_ROOM)) rdSel = SEL_CMD_ROOM;
      else if (at(reqAddr, OFF_TX_ROOM))  rdSel = SEL_TX_ROOM;
      else if (at(reqAddr, OFF_RX_LEVEL)) rdSel = SEL_RX_LEVEL;
      else if (at(reqAddr, OFF_RX_POP))   rdSel = SEL_RX_HEAD;
      else if (at(reqAddr, OFF_RX_PEEK))  rdSel = SEL_RX_HEAD;
      else                                rdSel = SEL_NONE;
    end
  end

  always_comb begin
    strb.accept    = accept;
    strb.wrEnable  = accept && isWr && at(reqAddr, OFF_ENABLE);
    strb.wrPending = accept && isWr && at(reqAddr, OFF_PENDING);
    strb.wrHold    = accept && isWr && at(reqAddr, OFF_HOLD);
    strb.popRx     = accept && isRd && at(reqAddr, OFF_RX_POP) && rxPopValid;
    strb.rdSel     = rdSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= accept;
  end

  assign reqAck       = ackQ;
  assign cmdPushValid = hitCmd;
  assign txPushValid  = hitTx;
  assign rxPopReady   = strb.popRx;

endmodule

// File: rtl/spi_regs_dp.sv
module spi_regs_dp
  import spi_regs_pkg::*;
#(
  parameter int LEVEL_W      = 5,
  parameter int DATA_W       = 8,
  parameter int SYNC_W       = 8,
  parameter int CMD_DEPTH    = 16,
  parameter int TX_DEPTH     = 16,
  parameter int CMD_LOW_MARK = 2,
  parameter int TX_LOW_MARK  = 2,
  parameter int RX_HIGH_MARK = 12,
  parameter int VER_MAJOR    = 1,
  parameter int VER_MINOR    = 0,
  parameter int VER_PATCH    = 8'h61
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [31:0]        wdata,
  input  logic [LEVEL_W-1:0] cmdLevel,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               rxPopValid,
  input  logic [DATA_W-1:0]  rxPopData,
  input  logic               syncValid,
  input  logic [SYNC_W-1:0]  syncId,
  output logic [31:0]        rdata,
  output logic               engineHold,
  output logic               irq
);

  localparam logic [31:0] VERSION_WORD =
    {8'h00, 8'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};

  logic [IRQ_W-1:0]  enableQ;
  logic [IRQ_W-1:0]  pendQ;
  logic [IRQ_W-1:0]  condV;
  logic [IRQ_W-1:0]  clearV;
  logic [IRQ_W-1:0]  masked;
  logic              holdQ;
  logic [SYNC_W-1:0] syncIdQ;
  logic [31:0]       rdataQ;
  logic [31:0]       rdMux;
  logic [31:0]       cmdRoom;
  logic [31:0]       txRoom;

  // Conditions sampled every cycle
  always_comb begin
    condV              = '0;
    condV[IRQ_CMD_LOW] = cmdLevel <= LEVEL_W'(CMD_LOW_MARK);
    condV[IRQ_TX_LOW]  = txLevel  <= LEVEL_W'(TX_LOW_MARK);
    condV[IRQ_RX_HIGH] = rxLevel  >= LEVEL_W'(RX_HIGH_MARK);
    condV[IRQ_SYNC]    = syncValid;
  end

  // Per-bit write-one-to-clear mask
  for (genvar b = 0; b < IRQ_W; b++) begin : g_clr
    assign clearV[b] = strb.wrPending & wdata[b];
  end

  assign masked  = pendQ & enableQ;
  assign cmdRoom = 32'(CMD_DEPTH) - 32'(cmdLevel);
  assign txRoom  = 32'(TX_DEPTH)  - 32'(txLevel);

  always_comb begin
    unique case (strb.rdSel)
      SEL_VERSION:  rdMux = VERSION_WORD;
      SEL_HOLD:     rdMux = 32'(holdQ);
      SEL_ENABLE:   rdMux = 32'(enableQ);
      SEL_PENDING:  rdMux = 32'(pendQ);
      SEL_SOURCE:   rdMux = 32'(masked);
      SEL_SYNC:     rdMux = 32'(syncIdQ);
      SEL_CMD_ROOM: rdMux = cmdRoom;
      SEL_TX_ROOM:  rdMux = txRoom;
      SEL_RX_LEVEL: rdMux = 32'(rxLevel);
      SEL_RX_HEAD:  rdMux = rxPopValid ? 32'(rxPopData) : 32'h0;
      default:      rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      pendQ   <= '0;
      holdQ   <= 1'b1;
      syncIdQ <= '0;
      rdataQ  <= '0;
    end else begin
      // A condition present in this cycle overrides a clear
      pendQ <= (pendQ & ~clearV) | condV;
      if (strb.wrEnable) enableQ <= wdata[IRQ_W-1:0];
      if (strb.wrHold)   holdQ   <= wdata[0];
      if (syncValid)     syncIdQ <= syncId;
      rdataQ <= strb.accept ? rdMux : 32'h0;
    end
  end

  logic unusedBits;
  assign unusedBits = ^wdata[31:IRQ_W];

  assign rdata      = rdataQ;
  assign engineHold = holdQ;
  assign irq        = |masked;

endmodule

// File: rtl/spi_regs_top.sv
module spi_regs_top
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int LEVEL_W      = 5,
  parameter int CMD_W        = 16,
  parameter int DATA_W       = 8,
  parameter int SYNC_W       = 8,
  parameter int CMD_DEPTH    = 16,
  parameter int TX_DEPTH     = 16,
  parameter int CMD_LOW_MARK = 2,
  parameter int TX_LOW_MARK  = 2,
  parameter int RX_HIGH_MARK = 12,
  parameter int VER_MAJOR    = 1,
  parameter int VER_MINOR    = 0,
  parameter int VER_PATCH    = 8'h61
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [31:0]        reqWdata,
  output logic               reqAck,
  output logic [31:0]        rspRdata,
  output logic               engineHold,
  output logic               irq,
  output logic               cmdPushValid,
  input  logic               cmdPushReady,
  output logic [CMD_W-1:0]   cmdPushData,
  input  logic [LEVEL_W-1:0] cmdLevel,
  output logic               txPushValid,
  input  logic               txPushReady,
  output logic [DATA_W-1:0]  txPushData,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic               rxPopValid,
  output logic               rxPopReady,
  input  logic [DATA_W-1:0]  rxPopData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               syncValid,
  input  logic [SYNC_W-1:0]  syncId
);

  ctrlStrobes_t strb;

  spi_regs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .cmdPushReady (cmdPushReady),
    .txPushReady  (txPushReady),
    .rxPopValid   (rxPopValid),
    .reqAck       (reqAck),
    .cmdPushValid (cmdPushValid),
    .txPushValid  (txPushValid),
    .rxPopReady   (rxPopReady),
    .strb         (strb)
  );

  spi_regs_dp #(
    .LEVEL_W      (LEVEL_W),
    .DATA_W       (DATA_W),
    .SYNC_W       (SYNC_W),
    .CMD_DEPTH    (CMD_DEPTH),
    .TX_DEPTH     (TX_DEPTH),
    .CMD_LOW_MARK (CMD_LOW_MARK),
    .TX_LOW_MARK  (TX_LOW_MARK),
    .RX_HIGH_MARK (RX_HIGH_MARK),
    .VER_MAJOR    (VER_MAJOR),
    .VER_MINOR    (VER_MINOR),
    .VER_PATCH    (VER_PATCH)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (reqWdata),
    .cmdLevel   (cmdLevel),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .rxPopValid (rxPopValid),
    .rxPopData  (rxPopData),
    .syncValid  (syncValid),
    .syncId     (syncId),
    .rdata      (rspRdata),
    .engineHold (engineHold),
    .irq        (irq)
  );

  assign cmdPushData = reqWdata[CMD_W-1:0];
  assign txPushData  = reqWdata[DATA_W-1:0];

endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqAck,
  input logic              engineHold,
  input logic              cmdPushValid,
  input logic              cmdPushReady,
  input logic              txPushValid,
  input logic              txPushReady,
  input logic              rxPopValid,
  input logic              rxPopReady
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck); // R11

  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $past(reqValid)); // R11

  AST_HOLD_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(engineHold) |-> $past(reqValid && reqWrite && reqAddr == ADDR_W'(OFF_HOLD))); // R3

  AST_CMD_PUSH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPushValid && cmdPushReady) |=> reqAck); // R9

  AST_TX_PUSH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (txPushValid && txPushReady) |=> reqAck); // R9

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPopReady |-> rxPopValid); // R10

endmodule

bind spi_regs_top spi_regs_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqWrite     (reqWrite),
  .reqAddr      (reqAddr),
  .reqAck       (reqAck),
  .engineHold   (engineHold),
  .cmdPushValid (cmdPushValid),
  .cmdPushReady (cmdPushReady),
  .txPushValid  (txPushValid),
  .txPushReady  (txPushReady),
  .rxPopValid   (rxPopValid),
  .rxPopReady   (rxPopReady)
);

// File: tb/sim_spi_regs_top.sv
module sim_spi_regs_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqAck;
  logic [31:0] rspRdata;
  logic        engineHold;
  logic        irq;
  logic        cmdPushValid;
  logic        cmdPushReady = 1'b0;
  logic [15:0] cmdPushData;
  logic [4:0]  cmdLevel = 5'd10;
  logic        txPushValid;
  logic        txPushReady = 1'b1;
  logic [7:0]  txPushData;
  logic [4:0]  txLevel = 5'd10;
  logic        rxPopValid = 1'b0;
  logic        rxPopReady;
  logic [7:0]  rxPopData = '0;
  logic [4:0]  rxLevel = 5'd0;
  logic        syncValid = 1'b0;
  logic [7:0]  syncId = '0;

  int totalChecks = 0;
  int failChecks  = 0;
  int ackCount    = 0;
  int reqCount    = 0;
  int cmdPushes   = 0;
  int txPushes    = 0;
  int rxPops      = 0;
  logic [15:0] lastCmd = '0;
  logic [7:0]  lastTx  = '0;
  bit finished = 0;

  logic [31:0] expQ [$];
  bit          chkQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regs_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .engineHold(engineHold), .irq(irq),
    .cmdPushValid(cmdPushValid), .cmdPushReady(cmdPushReady),
    .cmdPushData(cmdPushData), .cmdLevel(cmdLevel),
    .txPushValid(txPushValid), .txPushReady(txPushReady),
    .txPushData(txPushData), .txLevel(txLevel),
    .rxPopValid(rxPopValid), .rxPopReady(rxPopReady),
    .rxPopData(rxPopData), .rxLevel(rxLevel),
    .syncValid(syncValid), .syncId(syncId)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  endtask

  // Scoreboard monitor: one queued item per acknowledge
  always begin
    @(posedge clk);
    #1;
    if (rstN && reqAck) begin
      ackCount++;
      if (expQ.size() == 0) begin
        check("R11 unexpected ack", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic bit          c = chkQ.pop_front();
        automatic string       t = tagQ.pop_front();
        if (c) check(t, rspRdata, e);
      end
    end
  end

  // FIFO handshake monitor, sampled after inputs settle
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rstN) begin
      if (cmdPushValid && cmdPushReady) begin cmdPushes++; lastCmd = cmdPushData; end
      if (txPushValid && txPushReady)   begin txPushes++;  lastTx  = txPushData;  end
      if (rxPopReady)                   rxPops++;
    end
  end

  task automatic busXfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         input bit chk, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    chkQ.push_back(chk);
    tagQ.push_back(tag);
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    reqValid = 1'b1;
    reqCount++;
    do begin
      @(posedge clk);
      #1;
    end while (!reqAck);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busXfer(1'b1, a, d, 1'b0, 32'h0, "write");
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busXfer(1'b0, a, 32'h0, 1'b1, exp, tag);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check("watchdog expired", 32'd1, 32'd0);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ack idle", {31'h0, reqAck}, 32'd0);
    check("R1 irq low", {31'h0, irq}, 32'd0);
    check("R1 engine held", {31'h0, engineHold}, 32'd1);
    rd(8'h80, 32'h0, "R1 enable reset");
    rd(8'h84, 32'h0, "R1 pending reset");

    // R2 identification word
    rd(8'h00, 32'h0001_0061, "R2 version");

    // R3 soft reset register
    wr(8'h40, 32'h0);
    check("R3 hold released", {31'h0, engineHold}, 32'd0);
    rd(8'h40, 32'h0, "R3 readback 0");
    wr(8'h40, 32'h1);
    check("R3 hold asserted", {31'h0, engineHold}, 32'd1);
    rd(8'h40, 32'h1, "R3 readback 1");
    wr(8'h40, 32'h0);

    // R4 enable register
    wr(8'h80, 32'hFFFF_FFF5);
    rd(8'h80, 32'h5, "R4 enable width");
    wr(8'h80, 32'hF);
    rd(8'h80, 32'hF, "R4 enable all");

    // R8 room and level counters
    cmdLevel = 5'd10; txLevel = 5'd3; rxLevel = 5'd5;
    settle();
    rd(8'hD0, 32'd6, "R8 cmd room");
    rd(8'hD4, 32'd13, "R8 tx room");
    rd(8'hD8, 32'd5, "R8 rx level");

    // R12 / R5 command low condition
    rd(8'h84, 32'h0, "R12 none above marks");
    cmdLevel = 5'd2;
    settle();
    rd(8'h84, 32'h1, "R12 cmd low at mark");
    cmdLevel = 5'd3;
    settle();
    rd(8'h84, 32'h1, "R5 pending sticky");
    wr(8'h84, 32'h1);
    rd(8'h84, 32'h0, "R5 write one clears");
    cmdLevel = 5'd0;
    settle();
    wr(8'h84, 32'hFF);
    rd(8'h84, 32'h1, "R5 held condition wins");
    cmdLevel = 5'd10;
    settle();
    wr(8'h84, 32'hFF);

    // R12 transmit low and receive high
    txLevel = 5'd2;
    settle();
    rd(8'h84, 32'h2, "R12 tx low");
    txLevel = 5'd10;
    settle();
    wr(8'h84, 32'h2);
    rxLevel = 5'd11;
    settle();
    rd(8'h84, 32'h0, "R12 rx below mark");
    rxLevel = 5'd12;
    settle();
    rd(8'h84, 32'h4, "R12 rx at mark");

    // R6 masking and irq
    check("R6 irq on", {31'h0, irq}, 32'd1);
    rd(8'h88, 32'h4, "R6 source");
    wr(8'h80, 32'hB);
    check("R6 irq masked", {31'h0, irq}, 32'd0);
    rd(8'h88, 32'h0, "R6 source masked");
    rd(8'h84, 32'h4, "R6 pending kept");
    rxLevel = 5'd5;
    settle();
    wr(8'h84, 32'hFF);

    // R7 sync capture
    @(negedge clk); syncValid = 1'b1; syncId = 8'h5A;
    @(negedge clk); syncValid = 1'b0;
    rd(8'hC0, 32'h5A, "R7 sync id");
    rd(8'h84, 32'h8, "R7 sync pending");
    check("R7 sync irq", {31'h0, irq}, 32'd1);
    @(negedge clk); syncValid = 1'b1; syncId = 8'hA5;
    @(negedge clk); syncValid = 1'b0;
    rd(8'hC0, 32'hA5, "R7 sync overwrite");
    wr(8'h84, 32'h8);
    check("R7 irq cleared", {31'h0, irq}, 32'd0);

    // R9 command push stalls until ready
    begin
      automatic int ackBefore = ackCount;
      fork
        wr(8'hE0, 32'h1234_ABCD);
        begin
          repeat (6) @(negedge clk);
          check("R9 stalled no ack", ackCount, ackBefore);
          check("R9 stalled no push", cmdPushes, 0);
          cmdPushReady = 1'b1;
        end
      join
    end
    check("R9 one push", cmdPushes, 1);
    check("R9 cmd data", {16'h0, lastCmd}, 32'h0000_ABCD);
    wr(8'hE4, 32'h0000_33C3);
    check("R9 tx push", txPushes, 1);
    check("R9 tx data", {24'h0, lastTx}, 32'h0000_00C3);

    // R10 receive peek and pop
    rxPopValid = 1'b1; rxPopData = 8'h77;
    rd(8'hEC, 32'h77, "R10 peek");
    check("R10 peek no pop", rxPops, 0);
    rd(8'hE8, 32'h77, "R10 pop data");
    check("R10 one pop", rxPops, 1);
    rxPopValid = 1'b0;
    rd(8'hE8, 32'h0, "R10 empty pop");
    check("R10 empty no pop", rxPops, 1);

    // R11 unmapped offsets and ack accounting
    rd(8'h44, 32'h0, "R11 unmapped read");
    wr(8'h20, 32'hF);
    rd(8'h80, 32'hB, "R11 unmapped write ignored");
    rd(8'h40, 32'h0, "R11 hold untouched");
    settle();
    check("R11 ack per request", ackCount, reqCount);

    finished = 1;
    report();
  end

endmodule